// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flagged Character Queue

This block receives asynchronous serial characters on a single line and hands them to a host as parallel bytes. The line is examined only on cycles where a one-cycle enable, pulsing sixteen times per bit period, is high. A falling edge on an idle line starts a frame. The edge is confirmed half a bit later, and each following bit is sampled once near its centre. The character length and the parity mode are set by configuration inputs. They are captured when a start bit is accepted, so the values in force at that moment apply to the whole frame.

Every finished character goes into a sixteen-entry first-in first-out queue. Each entry holds the character together with three flags of its own: parity error, framing error and break. The host reads the queue through a registered port. The block also gives a data-ready flag. A sticky overrun flag, kept apart from the per-character flags, reports a character that found the queue full and was thrown away.

Top module: `serial_rx_queue`

## Requirements
- R1: `cfg_len` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits. Data bits arrive least significant first, and `rd_data` bits above the character length read as zero.
- R2: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd` = 0 expects an even count of ones over data and parity, and 1 expects an odd count. A mismatch sets `rd_perr` for that entry. With `cfg_par_en` = 0 no parity bit is expected and `rd_perr` is 0.
- R3: After a high-to-low change seen on a tick, the line is checked again on the 8th following tick. If it is high there, the start is discarded and no entry is written. Low pulses shorter than 8 ticks therefore produce nothing.
- R4: Every data, parity and stop bit is sampled on the 16th tick after the previous sample. A stop bit sampled low sets `rd_ferr`.
- R5: A frame whose data bits, parity bit (when enabled) and stop bit are all zero is stored with `rd_brk` = 1 and `rd_ferr` = 1. A line held low for many bit times yields exactly one entry, and the next frame needs the line to go high and then fall.
- R6: Characters leave the queue in arrival order. A one-cycle `rd_en` while `data_ready` is 1 pops the oldest entry, and its `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` are valid from the next cycle until the next pop. `data_ready` is 1 whenever the queue holds at least one entry.
- R7: The queue holds 16 entries. A character that completes while 16 are held is dropped, the stored 16 are kept intact, and `overrun` is set. `overrun` stays set until the next `rd_en`.
- R8: `rd_en` while the queue is empty changes neither `rd_data` nor the flags, and `data_ready` stays 0.
- R9: After `rst`, `data_ready` and `overrun` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 8 | Popped character |
| rd_perr | output | 1 | Parity error of popped entry |
| rd_ferr | output | 1 | Framing error of popped entry |
| rd_brk | output | 1 | Break flag of popped entry |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | A character was dropped on a full queue |

## Verification
The hardest situation to reach is a break frame that follows a long low line, because it depends on the parity setting and on edge re-arming after the frame. The bench holds the line low for twenty bit times under odd parity and also with no parity. It then checks that one flagged entry appears and no second one. The overrun case needs seventeen back-to-back frames with no reads in between. A directed burst reaches it, and all sixteen kept entries are read back afterwards. Random frames with injected parity flips and low stop bits cover the remaining flag combinations.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rxq_framer.sv
module rxq_framer import rxq_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rx,
  input  logic [1:0] cfg_len,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF_M1 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bit_idx;
  logic [2:0]        last_q;
  logic              pen_q, podd_q;
  logic [DATA_W-1:0] dat;
  logic              pbit;
  logic              prev;
  logic              mid;

  assign mid = tick && (cnt == FULL_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      last_q  <= 3'd7;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      dat     <= '0;
      pbit    <= 1'b0;
      prev    <= 1'b1;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick) prev <= rx;
      case (state)
        S_IDLE: begin
          if (tick && prev && !rx) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == HALF_M1) begin
              cnt <= '0;
              if (!rx) begin
                state   <= S_DATA;
                bit_idx <= '0;
                dat     <= '0;
                pbit    <= 1'b0;
                last_q  <= 3'd4 + {1'b0, cfg_len};
                pen_q   <= cfg_par_en;
                podd_q  <= cfg_par_odd;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (mid) begin
            cnt          <= '0;
            dat[bit_idx] <= rx;
            if (bit_idx == last_q) state <= pen_q ? S_PAR : S_STOP;
            else                   bit_idx <= bit_idx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (mid) begin
            cnt   <= '0;
            pbit  <= rx;
            state <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (mid) begin
            cnt           <= '0;
            push_o        <= 1'b1;
            entry_o.data  <= dat;
            entry_o.perr  <= pen_q & (^dat ^ pbit ^ podd_q);
            entry_o.ferr  <= !rx;
            entry_o.brk   <= (dat == '0) && !(pen_q && pbit) && !rx;
            state         <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && tick && cnt == HALF_M1 && rx) |=> (state == S_IDLE && !push_o));

  p_brk_has_ferr_r5: assert property (@(posedge clk) disable iff (rst)
    (push_o && entry_o.brk) |-> entry_o.ferr);

  p_one_push_r6: assert property (@(posedge clk) disable iff (rst)
    push_o |=> !push_o);

  p_ferr_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP && mid) |=> (push_o && entry_o.ferr == !$past(rx)));
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo import rxq_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  input  logic      rd_en,
  output rx_entry_t rd_entry,
  output logic      full,
  output logic      not_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  rx_entry_t   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_next;
  logic          wr_ok, rd_ok;

  assign full  = (cnt == FULL_CNT);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && (cnt != '0);

  always_comb begin
    cnt_next = cnt;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_next = cnt + 1'b1;
      2'b01:   cnt_next = cnt - 1'b1;
      default: cnt_next = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      not_empty <= 1'b0;
      rd_entry  <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) begin
        rp       <= rp + 1'b1;
        rd_entry <= mem[rp];
      end
      cnt       <= cnt_next;
      not_empty <= (cnt_next != '0);
    end
  end

  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (full && $stable(wp)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt == '0 && !wr_en) |=> ($stable(rd_entry) && !not_empty));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue import rxq_pkg::*; #(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       data_ready,
  output logic       overrun
);
  logic      rx_s;
  logic      push;
  rx_entry_t entry;
  rx_entry_t head;
  logic      q_full;

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
  );

  rxq_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .push_o(push), .entry_o(entry)
  );

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_entry(entry),
    .rd_en(rd_en), .rd_entry(head), .full(q_full), .not_empty(data_ready)
  );

  always_ff @(posedge clk) begin
    if (rst)                 overrun <= 1'b0;
    else if (push && q_full) overrun <= 1'b1;
    else if (rd_en)          overrun <= 1'b0;
  end

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

  p_ovr_set_r7: assert property (@(posedge clk) disable iff (rst)
    (push && q_full) |=> overrun);

  p_ready_after_push_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !q_full) |=> data_ready);
endmodule

// File: tb/test_serial_rx_queue.sv
module test_serial_rx_queue;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_ready, overrun;

  int checks = 0;
  int errors = 0;
  logic [10:0] expq [16];
  int exp_cnt = 0;
  int cycles = 0;

  serial_rx_queue i_serial_rx_queue (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .data_ready(data_ready), .overrun(overrun)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        tick16 = (i == 0);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles == 190000) begin
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_entry(int len, bit pen, bit podd,
                                            logic [7:0] d, bit flip, bit stp);
    logic [7:0] dm;
    bit pb;
    dm = d & 8'((1 << len) - 1);
    pb = (^dm) ^ podd ^ flip;
    return {(dm == 8'h00) && !(pen && pb) && !stp, !stp, pen && flip, dm};
  endfunction

  task automatic hold(bit v, int nticks);
    rxd = v;
    repeat (nticks * TDIV) @(negedge clk);
  endtask

  task automatic model_push(logic [10:0] e);
    if (exp_cnt < 16) begin
      expq[exp_cnt] = e;
      exp_cnt++;
    end
  endtask

  task automatic send(int len, bit pen, bit podd, logic [7:0] d, bit flip, bit stp);
    bit pb;
    cfg_len = 2'(len - 5);
    cfg_par_en = pen;
    cfg_par_odd = podd;
    pb = (^(d & 8'((1 << len) - 1))) ^ podd ^ flip;
    hold(1'b0, 16);
    for (int i = 0; i < len; i++) hold(d[i], 16);
    if (pen) hold(pb, 16);
    hold(stp, 16);
    hold(1'b1, 32);
    model_push(exp_entry(len, pen, podd, d, flip, stp));
  endtask

  task automatic pop;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic read_check(string req);
    pop();
    check(req, {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, expq[0]});
    for (int i = 0; i < 15; i++) expq[i] = expq[i+1];
    exp_cnt--;
  endtask

  task automatic drain(string req);
    while (exp_cnt > 0) read_check(req);
    check("R6 empty after drain", {31'd0, data_ready}, 32'd0);
  endtask

  initial begin
    logic [10:0] last;
    void'($urandom(32'd7741));
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 data_ready after reset", {31'd0, data_ready}, 32'd0);
    check("R9 overrun after reset", {31'd0, overrun}, 32'd0);

    // R1 directed lengths
    send(5, 0, 0, 8'hFF, 0, 1);
    send(6, 0, 0, 8'hA5, 0, 1);
    send(7, 0, 0, 8'h81, 0, 1);
    send(8, 0, 0, 8'h3C, 0, 1);
    check("R6 data_ready with entries", {31'd0, data_ready}, 32'd1);
    drain("R1 length and bit order");

    // R2 parity modes
    send(8, 1, 0, 8'h13, 0, 1);
    send(8, 1, 1, 8'h13, 0, 1);
    send(7, 1, 0, 8'h55, 1, 1);
    send(5, 1, 1, 8'h0E, 1, 1);
    drain("R2 parity");

    // R4 framing
    send(8, 0, 0, 8'h55, 0, 0);
    send(6, 1, 0, 8'h00, 1, 0);
    drain("R4 framing");

    // R3 false start: short low pulse
    hold(1'b0, 5);
    hold(1'b1, 48);
    check("R3 false start ignored", {31'd0, data_ready}, 32'd0);

    // R5 break, odd parity then no parity
    cfg_len = 2'b11; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    hold(1'b0, 16 * 20);
    hold(1'b1, 32);
    model_push(exp_entry(8, 1, 1, 8'h00, 1, 0));
    check("R5 single break entry", {28'd0, 4'(exp_cnt)}, 32'd1);
    read_check("R5 break odd parity");
    check("R5 no second entry", {31'd0, data_ready}, 32'd0);
    cfg_par_en = 1'b0;
    hold(1'b0, 16 * 20);
    hold(1'b1, 32);
    model_push(exp_entry(8, 0, 0, 8'h00, 0, 0));
    read_check("R5 break no parity");
    check("R5 no second entry", {31'd0, data_ready}, 32'd0);

    // R8 read while empty
    last = {rd_brk, rd_ferr, rd_perr, rd_data};
    pop();
    check("R8 empty read holds", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, last});
    check("R8 data_ready stays 0", {31'd0, data_ready}, 32'd0);

    // R7 overrun
    for (int k = 0; k < 17; k++) send(8, 0, 0, 8'(k * 13 + 1), 0, 1);
    check("R7 overrun set", {31'd0, overrun}, 32'd1);
    check("R7 queue full", {28'd0, 4'(exp_cnt - 1)}, 32'd15);
    read_check("R7 first kept entry");
    check("R7 overrun cleared by read", {31'd0, overrun}, 32'd0);
    drain("R7 kept entries");

    // Random frames
    for (int n = 0; n < 40; n++) begin
      int len;
      bit pen, podd, flip, stp;
      logic [7:0] d;
      len  = 5 + int'($urandom_range(0, 3));
      pen  = 1'($urandom_range(0, 1));
      podd = 1'($urandom_range(0, 1));
      flip = pen && ($urandom_range(0, 5) == 0);
      stp  = ($urandom_range(0, 5) != 0);
      d    = 8'($urandom);
      send(len, pen, podd, d, flip, stp);
      check("R6 data_ready random", {31'd0, data_ready}, 32'd1);
      if (exp_cnt >= 12 || $urandom_range(0, 3) == 0) drain("R6 random order and flags");
    end
    drain("R6 random final");
    check("R7 no overrun in random", {31'd0, overrun}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule